// File: doc/BRIEF.md
# Paged Graphic Display Host Port

This block is the host-facing side of a monochrome bitmap display controller. The display memory is split into a left and a right half. Each half holds 8 pages of 64 columns, and every byte stores 8 vertically stacked pixels. A host drives the port with an 8-bit data bus, a register select (`bus_rs`), a read/write line (`bus_rw`), an enable strobe (`bus_e`) and two active-low half selects. The enable strobe is resynchronised onto the system clock. Each operation takes effect when the block detects the strobe's falling edge.

Each half has its own set of state: a page register, a column counter that steps after every data access, a start-line register, a display-enable flag, a busy timer, an initialisation timer and a one-byte read buffer. Data reads go through that buffer. A read returns whatever the buffer held and then refills it from memory. As a result, the first read after the address changes returns stale data. The bidirectional bus appears as separate in, out and output-enable signals; the pad logic combines them.

Top module: `gdisp_host_port`

## Requirements
- R1: `{bus_rs,bus_rw}` select the access. `11` is a data read, `10` a data write, `01` a status read and `00` an instruction. A data write stores `bus_din` at the selected half's current page and column.
- R2: These instruction bytes apply to each selected half:
  - `01cccccc` loads the column.
  - `10111ppp` loads the page.
  - `11ssssss` loads the start line, which appears on `start_line_o` (left half in bits 5:0, right half in bits 11:6).
  - `0011111d` sets the display-enable flag, which appears on `disp_on_o` (bit 0 left, bit 1 right).
- R3: The status byte has busy in bit 7 and display-off in bit 5 (1 = off). Bit 4 is initialisation in progress. Bits 6 and 3:0 are 0.
- R4: Every accepted data read or write adds 1 to the column, wrapping from 63 to 0. The page does not change.
- R5: A data read returns the buffer, then loads the buffer from memory at the current address and advances the column. The first read after setting an address therefore returns the previous buffer contents.
- R6: `sel_l_n` low selects the left half and `sel_r_n` low selects the right half.
  - With both selects high, an access has no effect and the bus stays undriven.
  - With both selects low, writes and instructions reach both halves, but a data read does nothing in either half.
- R7: `bus_oe` is 1 only while `bus_rw` is 1, the synchronised strobe is high, and exactly one select is low.
- R8: Reset clears the start line to 0 and turns the display off. For INIT_CYCLES clocks after reset, only status reads are served and status bit 4 reads 1.
- R9: After each accepted data access or instruction, busy reads 1 for BUSY_CYCLES clocks. An access that completes while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_e | input | 1 | Host enable strobe (asynchronous) |
| bus_rs | input | 1 | 1 = display data, 0 = control/status |
| bus_rw | input | 1 | 1 = read, 0 = write |
| sel_l_n | input | 1 | Active-low left-half select |
| sel_r_n | input | 1 | Active-low right-half select |
| bus_din | input | 8 | Host write data |
| bus_dout | output | 8 | Read data toward host |
| bus_oe | output | 1 | Drive enable for `bus_dout` |
| disp_on_o | output | 2 | Display-enable flag per half |
| start_line_o | output | 12 | Start line per half, 6 bits each |

## Verification
A wrong column or page register becomes visible on the next data read. Because of the read buffer, it appears one read later than the access that corrupted it, so the bench always reads full 64-byte runs and checks each returned byte against an arithmetic pattern. Two other faults show up within one strobe cycle of the next status read:
- a busy timer that stays high too long or clears too early;
- a missed rejection, which also shifts every byte that follows it in the readback.

Errors in the select decoding show up as a driven bus or a written byte in the wrong half.

// File: rtl/gdisp_pkg.sv
package gdisp_pkg;

  // Access kind, encoded as {rs, rw}
  typedef enum logic [1:0] {
    ACC_INSTR  = 2'b00,
    ACC_STATUS = 2'b01,
    ACC_WRITE  = 2'b10,
    ACC_READ   = 2'b11
  } acc_e;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_COL,
    CMD_PAGE,
    CMD_START,
    CMD_ONOFF
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic [7:0] b);
    cmd_e c;
    if (b[7:6] == 2'b01)           c = CMD_COL;
    else if (b[7:3] == 5'b10111)   c = CMD_PAGE;
    else if (b[7:6] == 2'b11)      c = CMD_START;
    else if (b[7:1] == 7'b0011111) c = CMD_ONOFF;
    else                           c = CMD_NONE;
    return c;
  endfunction

endpackage

// File: rtl/gdisp_estrobe.sv
// Strobe synchroniser, falling-edge detector and bus capture.
module gdisp_estrobe #(
  parameter int SEL_N = 2,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             e_raw,
  input  logic             rs_raw,
  input  logic             rw_raw,
  input  logic [SEL_N-1:0] sel_n_raw,
  input  logic [DW-1:0]    din_raw,
  output logic             e_high,
  output logic             e_fall,
  output logic             cap_rs,
  output logic             cap_rw,
  output logic [SEL_N-1:0] cap_sel_n,
  output logic [DW-1:0]    cap_din
);

  logic [2:0]       sync_q;
  logic [2:0]       sync_d;
  logic             rs_d, rw_d;
  logic [SEL_N-1:0] sel_d;
  logic [DW-1:0]    din_d;

  always_comb begin
    sync_d = {sync_q[1:0], e_raw};
    rs_d   = cap_rs;
    rw_d   = cap_rw;
    sel_d  = cap_sel_n;
    din_d  = cap_din;
    // Capture bus fields while the first stage sees the strobe high
    if (sync_q[0]) begin
      rs_d  = rs_raw;
      rw_d  = rw_raw;
      sel_d = sel_n_raw;
      din_d = din_raw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      cap_rs    <= 1'b0;
      cap_rw    <= 1'b1;
      cap_sel_n <= '1;
      cap_din   <= '0;
    end else begin
      sync_q    <= sync_d;
      cap_rs    <= rs_d;
      cap_rw    <= rw_d;
      cap_sel_n <= sel_d;
      cap_din   <= din_d;
    end
  end

  assign e_high = sync_q[1];
  assign e_fall = sync_q[2] & ~sync_q[1];

endmodule

// File: rtl/gdisp_half.sv
// One display half: address state, bitmap storage, read buffer, timers.
module gdisp_half
  import gdisp_pkg::*;
#(
  parameter int COLS        = 64,
  parameter int PAGES       = 8,
  parameter int BUSY_CYCLES = 3,
  parameter int INIT_CYCLES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       commit,
  input  logic                       sel,
  input  logic                       multi_sel,
  input  logic                       rs,
  input  logic                       rw,
  input  logic [7:0]                 din,
  output logic                       busy,
  output logic                       init_act,
  output logic                       took,
  output logic                       disp_on,
  output logic [$clog2(PAGES*8)-1:0] start_line,
  output logic [7:0]                 rbuf,
  output logic [7:0]                 status
);

  localparam int COL_W  = $clog2(COLS);
  localparam int PAGE_W = $clog2(PAGES);
  localparam int LINE_W = $clog2(PAGES*8);
  localparam int ADDR_W = COL_W + PAGE_W;
  localparam int DEPTH  = COLS * PAGES;
  localparam int BCNT_W = $clog2(BUSY_CYCLES + 1);
  localparam int ICNT_W = $clog2(INIT_CYCLES + 1);

  logic [COL_W-1:0]  col_q, col_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [LINE_W-1:0] start_q, start_d;
  logic              on_q, on_d;
  logic [7:0]        buf_q, buf_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic [ICNT_W-1:0] icnt_q, icnt_d;
  logic              mem_we;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        mem [DEPTH];
  logic [7:0]        rd_word;
  acc_e              acc;
  cmd_e              cmd;

  assign addr     = {page_q, col_q};
  assign rd_word  = mem[addr];
  assign acc      = acc_e'({rs, rw});
  assign cmd      = decode_cmd(din);
  assign init_act = (icnt_q != '0);
  assign busy     = init_act | (bcnt_q != '0);

  always_comb begin
    col_d   = col_q;
    page_d  = page_q;
    start_d = start_q;
    on_d    = on_q;
    buf_d   = buf_q;
    mem_we  = 1'b0;
    took    = 1'b0;
    icnt_d  = init_act ? icnt_q - ICNT_W'(1) : icnt_q;
    bcnt_d  = (bcnt_q != '0) ? bcnt_q - BCNT_W'(1) : bcnt_q;
    if (commit && sel && !busy) begin
      unique case (acc)
        ACC_WRITE: begin
          mem_we = 1'b1;
          col_d  = col_q + COL_W'(1);
          took   = 1'b1;
        end
        ACC_READ: begin
          if (!multi_sel) begin
            buf_d = rd_word;
            col_d = col_q + COL_W'(1);
            took  = 1'b1;
          end
        end
        ACC_INSTR: begin
          took = 1'b1;
          unique case (cmd)
            CMD_COL:   col_d   = din[COL_W-1:0];
            CMD_PAGE:  page_d  = din[PAGE_W-1:0];
            CMD_START: start_d = din[LINE_W-1:0];
            CMD_ONOFF: on_d    = din[0];
            default:   ;
          endcase
        end
        default: ;
      endcase
      if (took) bcnt_d = BCNT_W'(BUSY_CYCLES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      page_q  <= '0;
      start_q <= '0;
      on_q    <= 1'b0;
      buf_q   <= '0;
      bcnt_q  <= '0;
      icnt_q  <= ICNT_W'(INIT_CYCLES);
    end else begin
      col_q   <= col_d;
      page_q  <= page_d;
      start_q <= start_d;
      on_q    <= on_d;
      buf_q   <= buf_d;
      bcnt_q  <= bcnt_d;
      icnt_q  <= icnt_d;
    end
  end

  // Bitmap storage has no reset
  always_ff @(posedge clk) begin
    if (mem_we) mem[addr] <= din;
  end

  assign disp_on    = on_q;
  assign start_line = start_q;
  assign rbuf       = buf_q;
  assign status     = {busy, 1'b0, ~on_q, init_act, 4'b0000};

endmodule

// File: rtl/gdisp_host_port.sv
module gdisp_host_port
  import gdisp_pkg::*;
#(
  parameter int COLS        = 64,
  parameter int PAGES       = 8,
  parameter int BUSY_CYCLES = 3,
  parameter int INIT_CYCLES = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_e,
  input  logic                           bus_rs,
  input  logic                           bus_rw,
  input  logic                           sel_l_n,
  input  logic                           sel_r_n,
  input  logic [7:0]                     bus_din,
  output logic [7:0]                     bus_dout,
  output logic                           bus_oe,
  output logic [1:0]                     disp_on_o,
  output logic [2*$clog2(PAGES*8)-1:0]   start_line_o
);

  localparam int HALVES = 2;
  localparam int LINE_W = $clog2(PAGES*8);

  logic              e_high, e_fall;
  logic              cap_rs, cap_rw;
  logic [HALVES-1:0] cap_sel_n;
  logic [7:0]        cap_din;
  logic [HALVES-1:0] busy_v, init_v, took_v;
  logic [7:0]        rbuf_v   [HALVES];
  logic [7:0]        status_v [HALVES];
  logic              multi_sel;
  logic              one_sel;
  logic              pick;
  logic              commit_any;
  logic              init_any;

  gdisp_estrobe #(.SEL_N(HALVES), .DW(8)) u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .e_raw     (bus_e),
    .rs_raw    (bus_rs),
    .rw_raw    (bus_rw),
    .sel_n_raw ({sel_r_n, sel_l_n}),
    .din_raw   (bus_din),
    .e_high    (e_high),
    .e_fall    (e_fall),
    .cap_rs    (cap_rs),
    .cap_rw    (cap_rw),
    .cap_sel_n (cap_sel_n),
    .cap_din   (cap_din)
  );

  assign multi_sel = (cap_sel_n == '0);

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    gdisp_half #(
      .COLS        (COLS),
      .PAGES       (PAGES),
      .BUSY_CYCLES (BUSY_CYCLES),
      .INIT_CYCLES (INIT_CYCLES)
    ) u_half (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit     (e_fall),
      .sel        (~cap_sel_n[h]),
      .multi_sel  (multi_sel),
      .rs         (cap_rs),
      .rw         (cap_rw),
      .din        (cap_din),
      .busy       (busy_v[h]),
      .init_act   (init_v[h]),
      .took       (took_v[h]),
      .disp_on    (disp_on_o[h]),
      .start_line (start_line_o[h*LINE_W +: LINE_W]),
      .rbuf       (rbuf_v[h]),
      .status     (status_v[h])
    );
  end

  assign commit_any = |took_v;
  assign init_any   = |init_v;

  // Read path toward the host
  assign one_sel = sel_l_n ^ sel_r_n;
  assign bus_oe  = bus_rw & e_high & one_sel;
  assign pick    = sel_l_n;

  always_comb begin
    bus_dout = 8'h00;
    if (bus_oe) begin
      bus_dout = bus_rs ? rbuf_v[pick] : status_v[pick];
    end
  end

endmodule

// File: rtl/gdisp_host_port_chk.sv
module gdisp_host_port_chk #(
  parameter int LW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_oe,
  input logic          bus_rw,
  input logic          bus_rs,
  input logic          sel_l_n,
  input logic          sel_r_n,
  input logic [7:0]    bus_dout,
  input logic [1:0]    disp_on_o,
  input logic [2*LW-1:0] start_line_o,
  input logic          commit_any,
  input logic          init_any
);

  // R7
  oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (bus_rw && (sel_l_n != sel_r_n)));

  // R6
  no_dual_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_l_n && !sel_r_n) |-> !bus_oe);

  // R3
  status_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !bus_rs) |-> (bus_dout[6] == 1'b0 && bus_dout[3:0] == 4'h0));

  // R2
  onoff_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp_on_o) |-> $past(commit_any));

  // R2
  start_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(start_line_o) |-> $past(commit_any));

  // R8
  init_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_any |=> ($stable(disp_on_o) && $stable(start_line_o)));

endmodule

bind gdisp_host_port gdisp_host_port_chk #(.LW(LINE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_oe       (bus_oe),
  .bus_rw       (bus_rw),
  .bus_rs       (bus_rs),
  .sel_l_n      (sel_l_n),
  .sel_r_n      (sel_r_n),
  .bus_dout     (bus_dout),
  .disp_on_o    (disp_on_o),
  .start_line_o (start_line_o),
  .commit_any   (commit_any),
  .init_any     (init_any)
);

// File: tb/gdisp_host_port_tb.sv
module gdisp_host_port_tb;

  localparam int INIT = 32;
  localparam logic [1:0] SL = 2'b10; // {r_n,l_n}: left only
  localparam logic [1:0] SR = 2'b01; // right only
  localparam logic [1:0] SB = 2'b00; // both
  localparam logic [1:0] SN = 2'b11; // none

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_e = 1'b0, bus_rs = 1'b0, bus_rw = 1'b1;
  logic        sel_l_n = 1'b1, sel_r_n = 1'b1;
  logic [7:0]  bus_din = 8'h00;
  logic [7:0]  bus_dout;
  logic        bus_oe;
  logic [1:0]  disp_on_o;
  logic [11:0] start_line_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gdisp_host_port #(.INIT_CYCLES(INIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_rs(bus_rs), .bus_rw(bus_rw),
    .sel_l_n(sel_l_n), .sel_r_n(sel_r_n), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .disp_on_o(disp_on_o),
    .start_line_o(start_line_o)
  );

  function automatic logic [7:0] pat(int h, int p, int c);
    return 8'((c*5 + p*29 + h*101 + 3));
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic op(input logic [1:0] seln, input logic rs, input logic rw,
                    input logic [7:0] d, output logic [7:0] rd, output logic ro);
    @(negedge clk);
    sel_l_n = seln[0]; sel_r_n = seln[1];
    bus_rs = rs; bus_rw = rw; bus_din = d; bus_e = 1'b1;
    repeat (4) @(negedge clk);
    rd = bus_dout; ro = bus_oe;
    bus_e = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic instr(input logic [1:0] seln, input logic [7:0] d);
    logic [7:0] r; logic o;
    op(seln, 1'b0, 1'b0, d, r, o);
  endtask

  task automatic wr(input logic [1:0] seln, input logic [7:0] d);
    logic [7:0] r; logic o;
    op(seln, 1'b1, 1'b0, d, r, o);
  endtask

  task automatic rdd(input logic [1:0] seln, output logic [7:0] r);
    logic o;
    op(seln, 1'b1, 1'b1, 8'h00, r, o);
  endtask

  task automatic stat(input logic [1:0] seln, output logic [7:0] r, output logic o);
    op(seln, 1'b0, 1'b1, 8'h00, r, o);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic o;
    logic [1:0] hs;
    repeat (5) @(negedge clk);
    chk("R8 reset display off", disp_on_o, 0);
    chk("R8 reset start line", start_line_o, 0);
    rst_n = 1'b1;

    // R8: instruction during init is rejected
    instr(SB, 8'h3F);
    stat(SL, r, o);
    chk("R8 status during init", r, 8'hB0);
    chk("R7 oe on status read", o, 1);
    repeat (INIT) @(negedge clk);
    chk("R8 display stays off", disp_on_o, 0);
    stat(SR, r, o);
    chk("R3 idle status off", r, 8'h20);

    // R2 on/off and R6 per-half selection
    instr(SB, 8'h3F);
    chk("R2 display on both", disp_on_o, 2'b11);
    stat(SL, r, o);
    chk("R3 status on", r, 8'h00);
    instr(SL, 8'h3E);
    chk("R6 off left only", disp_on_o, 2'b10);
    instr(SL, 8'hC0 | 8'd37);
    instr(SR, 8'hC0 | 8'd5);
    chk("R2 start lines", start_line_o, {6'd5, 6'd37});
    instr(SB, 8'h3A); // unassigned pattern
    chk("R2 unknown byte no change", start_line_o, {6'd5, 6'd37});

    // R1/R4 sweep writes
    for (int h = 0; h < 2; h++) begin
      hs = (h == 0) ? SL : SR;
      for (int p = 0; p < 8; p++) begin
        instr(hs, 8'hB8 | 8'(p));
        instr(hs, 8'h40);
        for (int c = 0; c < 64; c++) wr(hs, pat(h, p, c));
      end
    end
    // R1/R5 sweep reads
    for (int h = 0; h < 2; h++) begin
      hs = (h == 0) ? SL : SR;
      for (int p = 0; p < 8; p++) begin
        instr(hs, 8'hB8 | 8'(p));
        instr(hs, 8'h40);
        rdd(hs, r);
        if (p > 0) chk("R5 dummy read stale", r, pat(h, p-1, 0));
        for (int c = 0; c < 64; c++) begin
          rdd(hs, r);
          chk("R1 readback", r, pat(h, p, c));
        end
      end
    end

    // R4 wrap 63 -> 0 on same page
    instr(SR, 8'hBB);
    instr(SR, 8'h7F);
    wr(SR, 8'hAA);
    wr(SR, 8'h55);
    instr(SR, 8'h7F);
    rdd(SR, r);
    rdd(SR, r);
    chk("R4 col 63", r, 8'hAA);
    rdd(SR, r);
    chk("R4 wrapped to col 0 same page", r, 8'h55);
    rdd(SR, r);
    chk("R4 col 1 untouched", r, pat(1, 3, 1));

    // R6 both-low write, both-low read
    instr(SB, 8'hBA);
    instr(SB, 8'h40 | 8'd10);
    wr(SB, 8'h3C);
    instr(SB, 8'h40 | 8'd10);
    rdd(SL, r); rdd(SL, r);
    chk("R6 dual write left", r, 8'h3C);
    rdd(SR, r); rdd(SR, r);
    chk("R6 dual write right", r, 8'h3C);
    instr(SB, 8'h40 | 8'd20);
    op(SB, 1'b1, 1'b1, 8'h00, r, o);
    chk("R6 R7 dual read not driven", o, 0);
    rdd(SL, r); rdd(SL, r);
    chk("R6 dual read no advance left", r, pat(0, 2, 20));
    rdd(SR, r); rdd(SR, r);
    chk("R6 dual read no advance right", r, pat(1, 2, 20));

    // R6 no select: ignored
    instr(SL, 8'h40 | 8'd30);
    op(SN, 1'b1, 1'b0, 8'hEE, r, o);
    op(SN, 1'b0, 1'b1, 8'h00, r, o);
    chk("R7 no select not driven", o, 0);
    instr(SL, 8'h40 | 8'd30);
    rdd(SL, r); rdd(SL, r);
    chk("R6 no select write ignored", r, pat(0, 2, 30));
    op(SL, 1'b1, 1'b0, 8'h00, r, o);
    chk("R7 write not driven", o, 0);

    // R9 busy visible in status
    instr(SL, 8'hB9);
    @(negedge clk);
    sel_l_n = 1'b0; sel_r_n = 1'b1;
    bus_rs = 1'b0; bus_rw = 1'b0; bus_din = 8'h45; bus_e = 1'b1;
    @(negedge clk); bus_e = 1'b0;
    @(negedge clk); bus_rw = 1'b1; bus_e = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 busy after instruction", bus_dout, 8'hA0);
    bus_e = 1'b0;
    repeat (12) @(negedge clk);
    stat(SL, r, o);
    chk("R9 busy cleared", r, 8'h20);

    // R9 access during busy is rejected
    @(negedge clk);
    bus_rs = 1'b1; bus_rw = 1'b0; bus_din = 8'h11; bus_e = 1'b1;
    @(negedge clk); bus_e = 1'b0;
    @(negedge clk); bus_din = 8'h22; bus_e = 1'b1;
    @(negedge clk); bus_e = 1'b0;
    repeat (12) @(negedge clk);
    instr(SL, 8'h45);
    rdd(SL, r); rdd(SL, r);
    chk("R9 first write taken", r, 8'h11);
    rdd(SL, r);
    chk("R9 busy write rejected", r, pat(0, 1, 6));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule